// File: doc/BRIEF.md
# I2C Byte-Stepped Bus Master

This block drives an I2C bus as its only master, one byte per CPU request. Software loads a byte into the data register and sets a transfer bit in the control register. Two qualifier bits in the same write decide the framing: one asks for a START before the byte, the other asks for a STOP after it. The block shifts the nine bit times on SDA and SCL, records the ninth bit as acknowledge status, and then either sends a STOP or parks the bus with SCL held low until the next request.

While the block is idle it rests in a passive slave-receive mode. A START-qualified byte is always sent as an address in master-transmit mode. If the slave acknowledges and the address carries the read flag, the block turns into a master-receiver for the following bytes. In that mode it drives the acknowledge bit itself, as ACK or NACK according to a control bit. Each received byte is copied into the data register and flagged to the CPU, with an optional interrupt. After a NACK, or after any byte without STOP, the CPU can chain a repeated START or ask for an abort that only sends STOP.

Open-drain lines appear as output enables (1 pulls the line low) plus an SDA input. SCL low and high phases are set by parameters in system clock cycles.

Top module: `i2cm_byte_master`

## Requirements
- R1: After reset both line enables are 0, the status register (address 2) reads 0, meaning mode code 0 = slave-receive, and `irq` is 0.
- R2: A control write (address 1) with bit 0 (START) and bit 2 (transfer) set while idle sends a START, then the data register (address 0) MSB first. During bit times SDA changes only while SCL is low, and the two enables never change in the same cycle.
- R3: SDA stays low for at least `HI_CNT` cycles after a START before SCL falls. SCL stays high for at least `HI_CNT` cycles before SDA rises for a STOP.
- R4: Status bit 2 takes the sampled ninth bit (0 ACK, 1 NACK) in both directions. After an acknowledged address whose bit 0 is 1, status bits [5:4] read 2 (master-receive). Otherwise they read 1 (master-transmit) while the bus is owned.
- R5: In master-receive mode the byte reaches the data register only after the ninth bit. Status bit 0 (receive full) rises in the same cycle that status bit 3 (transfer) clears. Reading address 0 clears receive full.
- R6: As master-receiver the block pulls SDA low in the ninth bit when control bit 3 is 0, and releases it when bit 3 is 1.
- R7: `irq` is high exactly when receive full is set and control bit 5 (interrupt enable) is 1.
- R8: After a byte sent without control bit 1 (STOP), SCL stays held low and status bit 1 (busy) stays 1 until the CPU acts.
- R9: After a byte sent with control bit 1 set, the block sends STOP. Busy stays 1 until the STOP has been placed on the bus, then drops to 0, and the mode returns to 0.
- R10: While the bus is held, START plus transfer sends a repeated START with no STOP, followed by the new address in the data register.
- R11: While the bus is held, control bit 4 (abort) with transfer clear sends a STOP and no further START or byte.
- R12: A transfer request without START while idle is dropped: no line moves and the transfer bit reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears receive full on address 0) |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Receive-full interrupt |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled level of the SDA line |

## Verification
A behavioural slave on the modelled wires answers one address and logs every written byte and every master acknowledge. The bench runs a plain write closed with STOP, an address that no slave answers, a two-byte read that ends with NACK plus STOP, and a write chained through a repeated START into a read. These separate the qualifier combinations: STOP after ACK, hold after NACK, abort, and repeated START. They also tell the transmit ninth-bit path apart from the receive one. A lone transfer request while idle checks that an unframed byte is dropped. A per-cycle monitor times START hold and STOP setup and flags any cycle in which both enables move.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_START, ST_BIT_LO, ST_BIT_HI, ST_HOLD,
      ST_RS_LO, ST_RS_HI, ST_STOP_A, ST_STOP_B, ST_STOP_C
   } phase_e;

   typedef enum logic [1:0] {
      MD_SLV = 2'd0,
      MD_MTX = 2'd1,
      MD_MRX = 2'd2
   } mode_e;

   localparam logic [1:0] RA_DATA = 2'd0;
   localparam logic [1:0] RA_CTRL = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;

   localparam int CB_START = 0;
   localparam int CB_STOP  = 1;
   localparam int CB_XFER  = 2;
   localparam int CB_NACK  = 3;
   localparam int CB_ABORT = 4;
   localparam int CB_IRQEN = 5;
endpackage

// File: rtl/i2cm_in_sync.sv
module i2cm_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else        ff <= STAGES'({ff, d});
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
   parameter int LO_CNT = 20,
   parameter int HI_CNT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_lo,
   input  logic load_hi,
   output logic done,
   output logic mid
);
   localparam int MAXC    = (LO_CNT > HI_CNT) ? LO_CNT : HI_CNT;
   localparam int CW      = $clog2(MAXC);
   localparam int LO_HALF = (LO_CNT - 1) / 2;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load_lo)       cnt <= CW'(LO_CNT - 1);
      else if (load_hi)       cnt <= CW'(HI_CNT - 1);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
   assign mid  = (cnt == CW'(LO_HALF));
endmodule

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (shift) q <= {q[W-2:0], din};
   end
endmodule

// File: rtl/i2cm_byte_master.sv
module i2cm_byte_master
   import i2cm_pkg::*;
#(
   parameter int LO_CNT      = 20,
   parameter int HI_CNT      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       sda_i
);
   localparam int BW  = 8;
   localparam int BCW = $clog2(BW + 1);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(BW);

   generate
      if (LO_CNT < 4) begin : g_bad_lo
         $error("LO_CNT must be at least 4");
      end
      if (HI_CNT < SYNC_STAGES + 2) begin : g_bad_hi
         $error("HI_CNT must exceed the input synchroniser depth by 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   phase_e state, nstate;
   mode_e  mode;
   logic c_start, c_stop, c_xfer, c_nack, c_abort, c_irqen;
   logic [BW-1:0]  dbuf, shift_q;
   logic [BCW-1:0] bit_cnt;
   logic sda_s, t_done, t_mid, load_lo, load_hi;
   logic begin_byte, bit_end, byte_end, stop_done;
   logic rx_full, nack_q, addr_flag, busy;
   logic scl_q, sda_q, scl_low_nxt, drive_bit, rx_byte;

   i2cm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2cm_phase_timer #(.LO_CNT(LO_CNT), .HI_CNT(HI_CNT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_lo(load_lo), .load_hi(load_hi),
      .done(t_done), .mid(t_mid));

   i2cm_shifter #(.W(BW)) u_sh (
      .clk(clk), .rst_n(rst_n), .load(begin_byte), .load_val(dbuf),
      .shift(bit_end && (bit_cnt != LAST_BIT)), .din(sda_s), .q(shift_q));

   always_comb begin
      nstate     = state;
      load_lo    = 1'b0;
      load_hi    = 1'b0;
      begin_byte = 1'b0;
      bit_end    = 1'b0;
      byte_end   = 1'b0;
      stop_done  = 1'b0;
      unique case (state)
         ST_IDLE: if (c_xfer && c_start) begin
            nstate = ST_START; load_hi = 1'b1; begin_byte = 1'b1;
         end
         ST_START:  if (t_done) begin nstate = ST_BIT_LO; load_lo = 1'b1; end
         ST_BIT_LO: if (t_done) begin nstate = ST_BIT_HI; load_hi = 1'b1; end
         ST_BIT_HI: if (t_done) begin
            bit_end = 1'b1;
            if (bit_cnt == LAST_BIT) begin
               byte_end = 1'b1;
               if (c_stop) begin nstate = ST_STOP_A; load_lo = 1'b1; end
               else        nstate = ST_HOLD;
            end else begin
               nstate = ST_BIT_LO; load_lo = 1'b1;
            end
         end
         ST_HOLD: begin
            if (c_abort) begin
               nstate = ST_STOP_A; load_lo = 1'b1;
            end else if (c_xfer) begin
               begin_byte = 1'b1; load_lo = 1'b1;
               nstate = c_start ? ST_RS_LO : ST_BIT_LO;
            end
         end
         ST_RS_LO:  if (t_done) begin nstate = ST_RS_HI;  load_hi = 1'b1; end
         ST_RS_HI:  if (t_done) begin nstate = ST_START;  load_hi = 1'b1; end
         ST_STOP_A: if (t_done) begin nstate = ST_STOP_B; load_hi = 1'b1; end
         ST_STOP_B: if (t_done) begin nstate = ST_STOP_C; load_hi = 1'b1; end
         ST_STOP_C: if (t_done) begin nstate = ST_IDLE;   stop_done = 1'b1; end
         default:   nstate = ST_IDLE;
      endcase
   end

   assign scl_low_nxt = (nstate == ST_BIT_LO) || (nstate == ST_HOLD) ||
                        (nstate == ST_RS_LO)  || (nstate == ST_STOP_A);
   assign rx_byte   = (mode == MD_MRX);
   assign drive_bit = (bit_cnt == LAST_BIT) ? (rx_byte & ~c_nack)
                                            : (~rx_byte & ~shift_q[BW-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mode      <= MD_SLV;
         c_start   <= 1'b0;  c_stop  <= 1'b0;  c_xfer  <= 1'b0;
         c_nack    <= 1'b0;  c_abort <= 1'b0;  c_irqen <= 1'b0;
         dbuf      <= '0;
         rx_full   <= 1'b0;
         nack_q    <= 1'b0;
         addr_flag <= 1'b0;
         bit_cnt   <= '0;
         scl_q     <= 1'b0;
         sda_q     <= 1'b0;
      end else begin
         state <= nstate;
         scl_q <= scl_low_nxt;

         if (nstate == ST_START && state != ST_START)          sda_q <= 1'b1;
         else if (nstate == ST_STOP_C && state != ST_STOP_C)   sda_q <= 1'b0;
         else if (state == ST_IDLE)                            sda_q <= 1'b0;
         else if (t_mid && state == ST_BIT_LO)                 sda_q <= drive_bit;
         else if (t_mid && state == ST_RS_LO)                  sda_q <= 1'b0;
         else if (t_mid && state == ST_STOP_A)                 sda_q <= 1'b1;

         if (begin_byte)   bit_cnt <= '0;
         else if (bit_end) bit_cnt <= bit_cnt + 1'b1;

         if (reg_rd && reg_addr == RA_DATA) rx_full <= 1'b0;

         if (state == ST_IDLE) begin
            if (c_xfer && !c_start) c_xfer <= 1'b0;
            if (c_abort)            c_abort <= 1'b0;
         end

         if (begin_byte) begin
            addr_flag <= c_start;
            if (c_start) mode <= MD_MTX;
         end

         if (byte_end) begin
            c_xfer  <= 1'b0;
            c_start <= 1'b0;
            nack_q  <= sda_s;
            if (addr_flag)
               mode <= (shift_q[0] && !sda_s) ? MD_MRX : MD_MTX;
            if (mode == MD_MRX) begin
               dbuf    <= shift_q;
               rx_full <= 1'b1;
            end
         end

         if (stop_done) begin
            mode    <= MD_SLV;
            c_stop  <= 1'b0;
            c_abort <= 1'b0;
            c_start <= 1'b0;
         end

         if (reg_wr) begin
            if (reg_addr == RA_DATA) dbuf <= reg_wdata;
            if (reg_addr == RA_CTRL) begin
               c_start <= reg_wdata[CB_START];
               c_stop  <= reg_wdata[CB_STOP];
               c_xfer  <= reg_wdata[CB_XFER];
               c_nack  <= reg_wdata[CB_NACK];
               c_abort <= reg_wdata[CB_ABORT];
               c_irqen <= reg_wdata[CB_IRQEN];
            end
         end
      end
   end

   assign busy   = (state != ST_IDLE);
   assign irq    = c_irqen & rx_full;
   assign scl_oe = scl_q;
   assign sda_oe = sda_q;

   always_comb begin
      unique case (reg_addr)
         RA_DATA: reg_rdata = dbuf;
         RA_CTRL: reg_rdata = {2'b00, c_irqen, c_abort, c_nack, c_xfer, c_stop, c_start};
         RA_STAT: reg_rdata = {2'b00, mode, c_xfer, nack_q, busy, rx_full};
         default: reg_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/i2cm_byte_master_chk.sv
module i2cm_byte_master_chk
   import i2cm_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   scl_oe,
   input logic   sda_oe,
   input phase_e state,
   input logic   busy,
   input logic   rx_full,
   input logic   xfer,
   input logic   nack
);
   // R2
   edges_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scl_oe) |-> $stable(sda_oe));

   // R2
   data_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BIT_HI && $past(state) == ST_BIT_HI) |-> $stable(sda_oe));

   // R5
   rx_full_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> !xfer);

   // R4
   nack_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(nack) |-> $past(state) == ST_BIT_HI);

   // R9
   busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(state) == ST_STOP_C);

   // R8
   hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_HOLD |-> scl_oe);

   // R1
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state) == ST_IDLE) |-> (!scl_oe && !sda_oe));
endmodule

bind i2cm_byte_master i2cm_byte_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .state(state), .busy(busy), .rx_full(rx_full), .xfer(c_xfer), .nack(nack_q));

// File: tb/sim_i2cm_byte_master.sv
module sim_i2cm_byte_master;
   localparam int LO = 20;
   localparam int HI = 16;
   localparam logic [6:0] SLV_ADDR = 7'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic irq, scl_oe, sda_oe;
   logic slv_low = 1'b0;
   logic sda_line, scl_line;

   assign sda_line = !(sda_oe || slv_low);
   assign scl_line = !scl_oe;

   i2cm_byte_master #(.LO_CNT(LO), .HI_CNT(HI), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_line));

   always #4 clk = ~clk;

   int tests = 0, fails = 0, cycles = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Behavioural slave and wire monitor
   byte wr_log[$];
   bit  mack_log[$];
   int  n_start = 0, n_stop = 0;
   bit  prev_scl = 1'b1, prev_sda = 1'b1, prev_scl_oe = 1'b0, prev_sda_oe = 1'b0;
   int  bitcnt = 0, rd_k = 0, hi_run = 0, since_start = -1;
   bit  is_addr = 1'b0, selected = 1'b0, reading = 1'b0;
   logic [7:0] sr = 8'h00, txb = 8'h00;

   always @(negedge clk) begin
      bit scl_n, sda_n;
      scl_n = scl_line;
      sda_n = sda_line;
      if (rst_n) begin
         // R2: the master never moves both lines in one cycle
         if (scl_oe != prev_scl_oe)
            chk("R2 same-cycle edge", {31'd0, sda_oe != prev_sda_oe}, 32'd0);
         if (scl_n) hi_run++; else hi_run = 0;
         if (since_start >= 0) since_start++;
         if (scl_n && prev_scl && prev_sda && !sda_n) begin
            n_start++; bitcnt = 0; is_addr = 1'b1; reading = 1'b0;
            selected = 1'b0; slv_low = 1'b0; rd_k = 0; since_start = 0;
         end else if (scl_n && prev_scl && !prev_sda && sda_n) begin
            // R3: STOP setup
            chk("R3 stop setup", {31'd0, hi_run >= HI}, 32'd1);
            n_stop++; bitcnt = 0; is_addr = 1'b0; selected = 1'b0;
            reading = 1'b0; slv_low = 1'b0;
         end else if (scl_n && !prev_scl) begin
            if (bitcnt < 8) sr = {sr[6:0], sda_n};
            else if (bitcnt == 8 && reading) begin
               mack_log.push_back(sda_n);
               if (sda_n) reading = 1'b0;
            end
            bitcnt++;
         end else if (!scl_n && prev_scl) begin
            if (since_start >= 0) begin
               // R3: START hold
               chk("R3 start hold", {31'd0, since_start >= HI}, 32'd1);
               since_start = -1;
            end
            if (bitcnt == 8) begin
               if (is_addr) begin
                  selected = (sr[7:1] == SLV_ADDR);
                  slv_low  = selected;
               end else if (selected && !reading && mack_log.size() >= 0 && !sr_read_mode()) begin
                  wr_log.push_back(sr);
                  slv_low = 1'b1;
               end else slv_low = 1'b0;
            end else if (bitcnt == 9) begin
               bitcnt  = 0;
               slv_low = 1'b0;
               if (is_addr) begin
                  is_addr = 1'b0;
                  reading = selected && sr[0];
                  rd_mode = reading;
               end
               if (reading) begin
                  txb = 8'hC0 + 8'(rd_k);
                  rd_k++;
                  slv_low = !txb[7];
               end
            end else if (reading && bitcnt >= 1 && bitcnt <= 7) begin
               slv_low = !txb[7 - bitcnt];
            end
         end
      end
      prev_scl = scl_n; prev_sda = sda_n;
      prev_scl_oe = scl_oe; prev_sda_oe = sda_oe;
   end

   bit rd_mode = 1'b0;
   function automatic bit sr_read_mode();
      return rd_mode;
   endfunction

   // CPU access helpers
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic wait_xfer();
      logic [7:0] s;
      for (int g = 0; g < 20000; g++) begin
         rd(2'd2, s);
         if (!s[3]) return;
      end
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int g = 0; g < 20000; g++) begin
         rd(2'd2, s);
         if (!s[1]) return;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] s, d;
      int st0, sp0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 scl_oe", {31'd0, scl_oe}, 32'd0);
      chk("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      rd(2'd2, s); chk("R1 status", {24'd0, s}, 32'h00);

      // Write: address then one data byte closed with STOP
      wr(2'd0, {SLV_ADDR, 1'b0}); wr(2'd1, 8'h05); wait_xfer();
      rd(2'd2, s);
      chk("R4 addr ack", {31'd0, s[2]}, 32'd0);
      chk("R4 mode tx", {30'd0, s[5:4]}, 32'd1);
      chk("R8 busy held", {31'd0, s[1]}, 32'd1);
      sp0 = n_stop;
      wr(2'd0, 8'h5A); wr(2'd1, 8'h06); wait_xfer();
      rd(2'd2, s);
      chk("R9 busy during stop", {31'd0, s[1]}, 32'd1);
      chk("R9 stop not yet out", n_stop, sp0);
      wait_idle();
      chk("R2 byte on wire", {31'd0, wr_log.size() == 1}, 32'd1);
      if (wr_log.size() > 0) chk("R2 byte value", {24'd0, wr_log[$]}, 32'h5A);
      chk("R9 stop sent", n_stop, sp0 + 1);
      rd(2'd2, s); chk("R9 idle mode", {24'd0, s & 8'h32}, 32'h00);

      // Address with no answer, held, then abort
      st0 = n_start;
      wr(2'd0, 8'h44); wr(2'd1, 8'h05); wait_xfer();
      rd(2'd2, s); chk("R4 addr nack", {31'd0, s[2]}, 32'd1);
      sp0 = n_stop;
      repeat (300) @(negedge clk);
      chk("R8 scl held", {31'd0, scl_oe}, 32'd1);
      chk("R8 no stop while held", n_stop, sp0);
      rd(2'd2, s); chk("R8 busy", {31'd0, s[1]}, 32'd1);
      wr(2'd1, 8'h10); wait_idle();
      chk("R11 stop only", n_stop, sp0 + 1);
      chk("R11 no new start", n_start, st0 + 1);

      // Read two bytes, ACK then NACK with STOP
      wr(2'd0, {SLV_ADDR, 1'b1}); wr(2'd1, 8'h25); wait_xfer();
      rd(2'd2, s);
      chk("R4 read addr ack", {31'd0, s[2]}, 32'd0);
      chk("R4 mode rx", {30'd0, s[5:4]}, 32'd2);
      chk("R5 no early full", {31'd0, s[0]}, 32'd0);
      wr(2'd1, 8'h24); wait_xfer();
      rd(2'd2, s);
      chk("R5 full set", {31'd0, s[0]}, 32'd1);
      chk("R7 irq on", {31'd0, irq}, 32'd1);
      chk("R6 master ack low", {31'd0, mack_log.size() > 0 ? mack_log[$] : 1'b1}, 32'd0);
      rd(2'd0, d); chk("R5 first byte", {24'd0, d}, 32'hC0);
      rd(2'd2, s); chk("R5 full cleared", {31'd0, s[0]}, 32'd0);
      chk("R7 irq off", {31'd0, irq}, 32'd0);
      sp0 = n_stop;
      wr(2'd1, 8'h2E); wait_xfer();
      rd(2'd2, s); chk("R9 busy while stopping", {31'd0, s[1]}, 32'd1);
      wait_idle();
      rd(2'd0, d); chk("R5 last byte", {24'd0, d}, 32'hC1);
      rd(2'd2, s); chk("R4 rx nack status", {31'd0, s[2]}, 32'd1);
      chk("R6 master nack", {31'd0, mack_log.size() > 0 ? mack_log[$] : 1'b0}, 32'd1);
      chk("R9 read stop", n_stop, sp0 + 1);

      // Chain: write byte, repeated START, read one byte, abort
      rd_mode = 1'b0;
      wr(2'd0, {SLV_ADDR, 1'b0}); wr(2'd1, 8'h05); wait_xfer();
      wr(2'd0, 8'h11); wr(2'd1, 8'h04); wait_xfer();
      if (wr_log.size() > 0) chk("R2 chained byte", {24'd0, wr_log[$]}, 32'h11);
      st0 = n_start; sp0 = n_stop;
      wr(2'd0, {SLV_ADDR, 1'b1}); wr(2'd1, 8'h05); wait_xfer();
      chk("R10 repeated start", n_start, st0 + 1);
      chk("R10 no stop between", n_stop, sp0);
      rd(2'd2, s); chk("R10 mode rx", {30'd0, s[5:4]}, 32'd2);
      wr(2'd1, 8'h0C); wait_xfer();
      rd(2'd2, s); chk("R5 full set chain", {31'd0, s[0]}, 32'd1);
      chk("R7 irq masked", {31'd0, irq}, 32'd0);
      chk("R8 held after nack", {31'd0, scl_oe}, 32'd1);
      rd(2'd0, d); chk("R10 data after restart", {24'd0, d}, 32'hC0);
      wr(2'd1, 8'h10); wait_idle();
      chk("R11 abort stop", n_stop, sp0 + 1);

      // Lone transfer while idle
      st0 = n_start;
      wr(2'd1, 8'h04);
      repeat (200) @(negedge clk);
      chk("R12 scl idle", {31'd0, scl_oe}, 32'd0);
      chk("R12 sda idle", {31'd0, sda_oe}, 32'd0);
      chk("R12 no start", n_start, st0);
      rd(2'd2, s); chk("R12 status", {24'd0, s & 8'h3A}, 32'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule